// File: doc/BRIEF.md
# Secondary Bus Request Arbiter

This block decides which of four external bus masters may drive the secondary side of a PCI-style bridge. Every request input and every grant output is active low. A request line that no device drives reads high through its pull-up and so counts as idle. In internal mode the block grants the bus round-robin to one master at a time. It keeps a grant for as long as that master holds its request. Once a grant line is released, the block keeps every grant off for a fixed minimum gap before it issues the next one.

A static strap input selects the arbitration mode. With the strap high, an arbiter outside the bridge owns the bus. Port 0 then changes role: request input 0 carries the external arbiter's grant to the bridge, and grant output 0 carries the bridge's own request, which follows a "bridge wants the bus" input. Grant outputs 1 to 3 stay released in this mode.

The block also produces the secondary reset and the drive-control outputs. Secondary reset is active while the primary reset is active or while a software reset-control bit is set. During secondary reset the control outputs are disabled and the address/data, command and parity lines are driven to zero. Outside reset, the block parks those lines on the bridge whenever the bus is idle and no master holds it.

Top module: `sec_bus_arbiter`

## Requirements
- R1: While `prim_rst_n` is low, `sec_rst_n` is low, all `gnt_n` bits are 1, `ctl_oe` is 0, and `park_oe` and `ad_zero` are 1.
- R2: While `sec_rst_ctl` is 1 (primary reset inactive), the outputs are forced to the same values as in R1 in the same cycle, and any held grant is lost. When the bit clears, `sec_rst_n`, `ctl_oe` and `ad_zero` return to 1, 1 and 0.
- R3: In internal mode (`ext_arb_strap` = 0), a master with `req_n[i]` = 0 and no grant active is granted by `gnt_n[i]` = 0 after the first clock edge at which the gap of R7 has elapsed.
- R4: In internal mode, at most one bit of `gnt_n` is 0 at any time.
- R5: Among the masters requesting at once, the grant goes to the first one found by searching upward from the index after the most recently granted index, wrapping from 3 to 0. After reset the search starts at index 0.
- R6: A grant stays active while its request stays low. It is released (`gnt_n[i]` = 1) on the first clock edge that samples `req_n[i]` = 1.
- R7: Once a grant output goes to 1, no grant output goes to 0 for at least 2 clock cycles.
- R8: A port whose `req_n` stays 1 is never granted.
- R9: In internal mode outside reset, `park_oe` is 1 exactly when no grant is active and `bus_busy` is 0.
- R10: In external mode (`ext_arb_strap` = 1), `gnt_n[3:1]` stay 1. `gnt_n[0]` is the inverse of `bridge_want`, and `bridge_gnt` is the inverse of `req_n[0]`; each takes the new value one clock edge after the input changes.
- R11: In external mode outside reset, `park_oe` is 1 exactly when `bridge_gnt` is 1 and `bus_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Secondary bus clock |
| prim_rst_n | input | 1 | Primary reset, active low, asynchronous |
| sec_rst_ctl | input | 1 | Software secondary-reset control bit, active high |
| ext_arb_strap | input | 1 | Static strap: 0 selects the internal arbiter, 1 selects an external arbiter |
| bus_busy | input | 1 | High while a transaction occupies the secondary bus |
| bridge_want | input | 1 | Bridge needs the bus (external mode) |
| req_n | input | 4 | Master requests, active low; in external mode bit 0 is the grant to the bridge |
| gnt_n | output | 4 | Master grants, active low; in external mode bit 0 is the bridge's request |
| bridge_gnt | output | 1 | Bridge holds the bus (external mode) |
| sec_rst_n | output | 1 | Secondary reset, active low |
| ctl_oe | output | 1 | Enable for the secondary control outputs |
| park_oe | output | 1 | Drive enable for the address/data, command and parity lines |
| ad_zero | output | 1 | Forces the driven address/data, command and parity values to zero |

## Verification
An ownership register stuck on the wrong index shows up at the first grant after reset or after a hand-over: `gnt_n` names the wrong master within one edge of the request pattern. A lost gap count shows as a grant that returns one cycle early right after a release. A wrong round-robin pointer reorders the grant sequence when several masters request at once. Reset forcing and the park logic are combinational from the registered state, so a fault there is visible in the same cycle as the reset bit or the bus-busy change.

// File: rtl/sba_pkg.sv
package sba_pkg;

    typedef enum logic {
        ARB_INTERNAL = 1'b0,
        ARB_EXTERNAL = 1'b1
    } arb_mode_e;

endpackage

// File: rtl/sba_rr_pick.sv
module sba_rr_pick #(
    parameter int NUM = 4,
    localparam int IW = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic [NUM-1:0] req,
    input  logic [IW-1:0]  last,
    output logic           found,
    output logic [IW-1:0]  idx
);
    int cand;

    // Search starts one past the last winner and wraps.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        cand  = 0;
        for (int k = 1; k <= NUM; k++) begin
            cand = (int'(last) + k) % NUM;
            if (!found && req[cand]) begin
                found = 1'b1;
                idx   = IW'(cand);
            end
        end
    end
endmodule

// File: rtl/sba_gap_timer.sv
module sba_gap_timer #(
    parameter int GAP = 2,
    localparam int CW = $clog2(GAP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    output logic ready
);
    localparam logic [CW-1:0] LOAD = CW'(GAP - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (start)
            cnt_d = LOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == '0);
endmodule

// File: rtl/sec_bus_arbiter.sv
module sec_bus_arbiter
    import sba_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int MIN_GAP     = 2
) (
    input  logic                   clk,
    input  logic                   prim_rst_n,
    input  logic                   sec_rst_ctl,
    input  logic                   ext_arb_strap,
    input  logic                   bus_busy,
    input  logic                   bridge_want,
    input  logic [NUM_MASTERS-1:0] req_n,
    output logic [NUM_MASTERS-1:0] gnt_n,
    output logic                   bridge_gnt,
    output logic                   sec_rst_n,
    output logic                   ctl_oe,
    output logic                   park_oe,
    output logic                   ad_zero
);
    localparam int IW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
    localparam logic [NUM_MASTERS-1:0] ONE = NUM_MASTERS'(1);
    localparam logic [IW-1:0] LAST_RST = IW'(NUM_MASTERS - 1);

    typedef struct packed {
        logic          gnt_on;
        logic [IW-1:0] owner;
        logic [IW-1:0] last;
        logic          breq;
        logic          bgnt;
    } arb_st_t;

    localparam arb_st_t ST_RST = '{gnt_on: 1'b0, owner: '0, last: LAST_RST,
                                   breq: 1'b0, bgnt: 1'b0};

    arb_st_t st_d, st_q;

    arb_mode_e               mode;
    logic                    in_rst;
    logic [NUM_MASTERS-1:0]  req_act;
    logic [NUM_MASTERS-1:0]  own_vec;
    logic                    pick_found;
    logic [IW-1:0]           pick_idx;
    logic                    gap_ready;
    logic                    drop;

    assign mode    = arb_mode_e'(ext_arb_strap);
    assign in_rst  = !prim_rst_n || sec_rst_ctl;
    assign req_act = ~req_n;
    assign own_vec = st_q.gnt_on ? (ONE << st_q.owner) : '0;

    sba_rr_pick #(.NUM(NUM_MASTERS)) u_pick (
        .req   (req_act),
        .last  (st_q.last),
        .found (pick_found),
        .idx   (pick_idx)
    );

    sba_gap_timer #(.GAP(MIN_GAP)) u_gap (
        .clk   (clk),
        .rst_n (prim_rst_n),
        .clr   (sec_rst_ctl),
        .start (drop),
        .ready (gap_ready)
    );

    // Next-state computation.
    always_comb begin
        st_d = st_q;
        drop = 1'b0;
        if (sec_rst_ctl) begin
            st_d = ST_RST;
        end else if (mode == ARB_EXTERNAL) begin
            st_d.gnt_on = 1'b0;
            st_d.breq   = bridge_want;
            st_d.bgnt   = req_act[0];
        end else begin
            st_d.breq = 1'b0;
            st_d.bgnt = 1'b0;
            if (st_q.gnt_on) begin
                if (!req_act[st_q.owner]) begin
                    st_d.gnt_on = 1'b0;
                    drop        = 1'b1;
                end
            end else if (gap_ready && pick_found) begin
                st_d.gnt_on = 1'b1;
                st_d.owner  = pick_idx;
                st_d.last   = pick_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge prim_rst_n) begin
        if (!prim_rst_n)
            st_q <= ST_RST;
        else
            st_q <= st_d;
    end

    // Output decode.
    always_comb begin
        sec_rst_n  = !in_rst;
        ctl_oe     = !in_rst;
        ad_zero    = in_rst;
        bridge_gnt = 1'b0;
        gnt_n      = '1;
        park_oe    = 1'b1;
        if (!in_rst) begin
            if (mode == ARB_EXTERNAL) begin
                gnt_n[0]   = !st_q.breq;
                bridge_gnt = st_q.bgnt;
                park_oe    = !bus_busy && st_q.bgnt;
            end else begin
                gnt_n   = ~own_vec;
                park_oe = !bus_busy && !st_q.gnt_on;
            end
        end
    end
endmodule

// File: rtl/sba_checker.sv
module sba_checker #(
    parameter int NUM_MASTERS = 4
) (
    input logic                   clk,
    input logic                   prim_rst_n,
    input logic                   sec_rst_ctl,
    input logic                   ext_arb_strap,
    input logic [NUM_MASTERS-1:0] req_n,
    input logic [NUM_MASTERS-1:0] gnt_n,
    input logic                   bridge_gnt,
    input logic                   sec_rst_n,
    input logic                   ctl_oe,
    input logic                   park_oe,
    input logic                   ad_zero
);
    p_sec_rst_force_r2: assert property (@(posedge clk) disable iff (!prim_rst_n)
        sec_rst_ctl |-> (&gnt_n && !ctl_oe && ad_zero && park_oe && !bridge_gnt && !sec_rst_n));

    p_one_grant_r4: assert property (@(posedge clk) disable iff (!prim_rst_n)
        !ext_arb_strap |-> $onehot0(~gnt_n));

    p_ext_upper_idle_r10: assert property (@(posedge clk) disable iff (!prim_rst_n)
        ext_arb_strap |-> &gnt_n[NUM_MASTERS-1:1]);

    for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_port
        p_gap_hold_r7: assert property (@(posedge clk) disable iff (!prim_rst_n)
            $rose(gnt_n[i]) |=> gnt_n[i]);

        p_release_r6: assert property (@(posedge clk) disable iff (!prim_rst_n || ext_arb_strap)
            (!gnt_n[i] && req_n[i]) |=> gnt_n[i]);

        p_grant_needs_req_r8: assert property (@(posedge clk) disable iff (!prim_rst_n || ext_arb_strap)
            $fell(gnt_n[i]) |-> $past(!req_n[i]));
    end
endmodule

bind sec_bus_arbiter sba_checker #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
    .clk           (clk),
    .prim_rst_n    (prim_rst_n),
    .sec_rst_ctl   (sec_rst_ctl),
    .ext_arb_strap (ext_arb_strap),
    .req_n         (req_n),
    .gnt_n         (gnt_n),
    .bridge_gnt    (bridge_gnt),
    .sec_rst_n     (sec_rst_n),
    .ctl_oe        (ctl_oe),
    .park_oe       (park_oe),
    .ad_zero       (ad_zero)
);

// File: tb/sec_bus_arbiter_test.sv
`timescale 1ns/1ps
module sec_bus_arbiter_test;
    logic       clk = 1'b0;
    logic       prim_rst_n = 1'b0;
    logic       sec_rst_ctl = 1'b0;
    logic       ext_arb_strap = 1'b0;
    logic       bus_busy = 1'b0;
    logic       bridge_want = 1'b0;
    logic [3:0] req_n = 4'hF;
    logic [3:0] gnt_n;
    logic       bridge_gnt, sec_rst_n, ctl_oe, park_oe, ad_zero;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sec_bus_arbiter uut (
        .clk           (clk),
        .prim_rst_n    (prim_rst_n),
        .sec_rst_ctl   (sec_rst_ctl),
        .ext_arb_strap (ext_arb_strap),
        .bus_busy      (bus_busy),
        .bridge_want   (bridge_want),
        .req_n         (req_n),
        .gnt_n         (gnt_n),
        .bridge_gnt    (bridge_gnt),
        .sec_rst_n     (sec_rst_n),
        .ctl_oe        (ctl_oe),
        .park_oe       (park_oe),
        .ad_zero       (ad_zero)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic apply_reset(input logic ext);
        @(negedge clk);
        prim_rst_n    = 1'b0;
        sec_rst_ctl   = 1'b0;
        ext_arb_strap = ext;
        bus_busy      = 1'b0;
        bridge_want   = 1'b0;
        req_n         = 4'hF;
        @(negedge clk);
        @(negedge clk);
        prim_rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R1: primary reset forcing
    task automatic t_reset();
        @(negedge clk);
        prim_rst_n = 1'b0;
        req_n      = 4'b1110;
        @(negedge clk);
        chk("R1 gnt_n", gnt_n, 4'hF);
        chk("R1 sec_rst_n", sec_rst_n, 0);
        chk("R1 ctl_oe", ctl_oe, 0);
        chk("R1 park_oe", park_oe, 1);
        chk("R1 ad_zero", ad_zero, 1);
        req_n = 4'hF;
    endtask

    // R3 grant, R6 hold/release, R7 gap, R9 park
    task automatic t_basic();
        apply_reset(1'b0);
        chk("R9 park idle", park_oe, 1);
        bus_busy = 1'b1;
        #1 chk("R9 park busy", park_oe, 0);
        bus_busy = 1'b0;
        req_n = 4'b1110;
        @(negedge clk);
        chk("R3 grant 0", gnt_n, 4'b1110);
        chk("R9 no park granted", park_oe, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R6 hold", gnt_n, 4'b1110);
        end
        req_n = 4'hF;
        @(negedge clk);
        chk("R6 release", gnt_n, 4'hF);
        req_n = 4'b1110;
        @(negedge clk);
        chk("R7 gap cycle 2", gnt_n, 4'hF);
        @(negedge clk);
        chk("R7 regrant after gap", gnt_n, 4'b1110);
        req_n = 4'hF;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_grant(input int exp_idx, input bit watch3);
        int idx;
        idx = -1;
        for (int n = 0; n < 10 && idx < 0; n++) begin
            @(negedge clk);
            chk("R4 one grant", $countones(~gnt_n), ($countones(~gnt_n) <= 1) ? $countones(~gnt_n) : 1);
            if (watch3) chk("R8 idle port 3", gnt_n[3], 1);
            for (int b = 0; b < 4; b++)
                if (!gnt_n[b]) idx = b;
        end
        chk("R5 rr order", idx, exp_idx);
        if (idx >= 0) req_n[idx] = 1'b1;
    endtask

    // R4, R5, R8: round-robin order and wrap
    task automatic t_rr();
        apply_reset(1'b0);
        req_n = 4'b1000;
        wait_grant(0, 1'b1);
        wait_grant(1, 1'b1);
        wait_grant(2, 1'b1);
        req_n = 4'b0101;
        wait_grant(3, 1'b0);
        wait_grant(1, 1'b0);
        req_n = 4'hF;
        @(negedge clk);
    endtask

    // R2: secondary reset bit
    task automatic t_secrst();
        apply_reset(1'b0);
        req_n = 4'b1101;
        @(negedge clk);
        chk("R2 pre grant", gnt_n, 4'b1101);
        sec_rst_ctl = 1'b1;
        #1;
        chk("R2 gnt_n", gnt_n, 4'hF);
        chk("R2 sec_rst_n", sec_rst_n, 0);
        chk("R2 ctl_oe", ctl_oe, 0);
        chk("R2 ad_zero", ad_zero, 1);
        chk("R2 park_oe", park_oe, 1);
        @(negedge clk);
        sec_rst_ctl = 1'b0;
        req_n = 4'hF;
        @(negedge clk);
        chk("R2 sec_rst_n back", sec_rst_n, 1);
        chk("R2 ctl_oe back", ctl_oe, 1);
        chk("R2 ad_zero back", ad_zero, 0);
    endtask

    // R10, R11: external arbiter mode
    task automatic t_ext();
        apply_reset(1'b1);
        bridge_want = 1'b1;
        req_n = 4'b0001;
        @(negedge clk);
        chk("R10 bridge request", gnt_n, 4'b1110);
        chk("R10 no bridge grant", bridge_gnt, 0);
        chk("R11 no park", park_oe, 0);
        req_n = 4'b0000;
        @(negedge clk);
        chk("R10 bridge grant", bridge_gnt, 1);
        chk("R10 upper grants idle", gnt_n[3:1], 3'b111);
        chk("R11 park", park_oe, 1);
        bus_busy = 1'b1;
        #1 chk("R11 park busy", park_oe, 0);
        bridge_want = 1'b0;
        @(negedge clk);
        chk("R10 request dropped", gnt_n, 4'hF);
        bus_busy = 1'b0;
        req_n = 4'hF;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_rr();
        t_secrst();
        t_ext();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule